// File: doc/BRIEF.md
# Condition Flag and Branch Resolution Unit

This block holds the single true/false condition bit of a small pipelined processor with 16-bit instructions. It also resolves that processor's branches. Each cycle it receives one decoded instruction:

- an operation class,
- two 32-bit register operands,
- the instruction's own program counter,
- an 8-bit branch displacement.

Only compare and test operations write the condition bit. Arithmetic and every other class leave it as it is.

The unit registers the address of the next instruction to fetch. A conditional branch tests the bit. When taken, it redirects on the next cycle and raises a one-cycle flush for the wrongly fetched instruction. An unconditional branch is delayed: the instruction in the following slot still executes, and only then does control move to the target. A branch placed in that slot is reported as illegal and is not taken.

Top module: `cond_branch_unit`

## Requirements
- R1: Operation class 2 (signed compare) sets `flag_o` to 1 on the next cycle when `opnd_a_i` is greater than or equal to `opnd_b_i`, both read as two's complement, and clears it otherwise.
- R2: Operation class 3 (unsigned compare) sets `flag_o` to 1 when `opnd_a_i` is greater than or equal to `opnd_b_i`, both read as unsigned, and clears it otherwise.
- R3: Operation class 4 (test) sets `flag_o` to 1 when the bitwise AND of the two operands is zero, and clears it otherwise.
- R4: Operation classes 0 (no-op), 1 (add) and 8 to 15 leave `flag_o` unchanged. Branch classes 5 to 7 also leave it unchanged.
- R5: Class 5 (branch if true) is taken when the flag is 1. Class 6 (branch if false) is taken when the flag is 0. When taken, `next_pc_o` equals the target one cycle later, and `flush_o` is 1 for exactly that cycle.
- R6: A non-branch, or a conditional branch that is not taken, gives `next_pc_o` = `op_pc_i` + 2 one cycle later with `flush_o` at 0.
- R7: Class 7 (unconditional branch) is delayed. One cycle later `next_pc_o` = `op_pc_i` + 2 with no flush. The next instruction executes, including any write to the flag. One cycle after that instruction, `next_pc_o` equals the branch target.
- R8: Any branch class (5, 6 or 7) in a delay slot is not taken. `illegal_o` is 1 for one cycle, and `next_pc_o` moves to the first branch's target.
- R9: During and just after synchronous reset, `next_pc_o` equals `reset_vec_i`, while `flag_o`, `flush_o` and `illegal_o` are 0.
- R10: A conditional branch issued in the cycle directly after a flag-writing instruction uses that instruction's new flag value.
- R11: The branch target is the branch's `op_pc_i` + 4 + (sign-extended `disp_i` × 2), wrapping modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reset_vec_i | input | 32 | Address loaded into `next_pc_o` while in reset |
| op_class_i | input | 4 | Decoded operation class |
| opnd_a_i | input | 32 | First register operand |
| opnd_b_i | input | 32 | Second register operand |
| op_pc_i | input | 32 | Address of the current instruction |
| disp_i | input | 8 | Signed branch displacement, in halfwords |
| flag_o | output | 1 | Condition bit |
| next_pc_o | output | 32 | Registered next fetch address |
| flush_o | output | 1 | Discard the instruction fetched after a taken conditional branch |
| illegal_o | output | 1 | A branch sat in a delay slot |

## Verification
Each result is due at a fixed delay after the edge that takes the instruction:

| Result | Due |
|---|---|
| Flag, flush, illegal indication and sequential or conditional next address | One edge later |
| Delayed-branch target | One edge after the slot instruction |

The bench drives each instruction on a falling edge and waits for one rising edge. It then compares on the following falling edge, before the next instruction is applied. Delayed branches are therefore checked twice: once for the slot address and once for the target.

// File: rtl/cbu_pkg.sv
package cbu_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_NOP    = 4'd0,
    OP_ADD    = 4'd1,
    OP_CMPGE  = 4'd2,
    OP_CMPGEU = 4'd3,
    OP_TST    = 4'd4,
    OP_BT     = 4'd5,
    OP_BF     = 4'd6,
    OP_BRA    = 4'd7
  } cbu_op_e;

  function automatic logic op_is_branch(input logic [OP_W-1:0] op);
    return (op == OP_BT) || (op == OP_BF) || (op == OP_BRA);
  endfunction
endpackage

// File: rtl/cbu_flag_unit.sv
module cbu_flag_unit
  import cbu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic              flag_o
);
  logic flag_q;
  logic flag_d;
  logic wr_en;

  always_comb begin
    wr_en  = 1'b1;
    flag_d = flag_q;
    case (op_i)
      OP_CMPGE:  flag_d = ($signed(a_i) >= $signed(b_i));
      OP_CMPGEU: flag_d = (a_i >= b_i);
      OP_TST:    flag_d = ((a_i & b_i) == '0);
      default:   wr_en  = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) flag_q <= 1'b0;
    else if (wr_en) flag_q <= flag_d;
  end

  assign flag_o = flag_q;

  a_r4_flag_hold: assert property (@(posedge clk) disable iff (rst)
    !(op_i inside {OP_CMPGE, OP_CMPGEU, OP_TST}) |=> $stable(flag_q));

  a_r1_signed_ge: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_CMPGE) |=> (flag_q == $past($signed(a_i) >= $signed(b_i))));

  a_r3_test_zero: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_TST) |=> (flag_q == ($past(a_i & b_i) == '0)));
endmodule

// File: rtl/cbu_target_calc.sv
module cbu_target_calc #(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 8
) (
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [DISP_W-1:0] disp_i,
  output logic [ADDR_W-1:0] seq_o,
  output logic [ADDR_W-1:0] target_o
);
  localparam int EXT_W = ADDR_W - DISP_W - 1;
  localparam logic [ADDR_W-1:0] INSN_BYTES = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] PIPE_AHEAD = ADDR_W'(4);

  logic [ADDR_W-1:0] offset;

  assign offset   = {{EXT_W{disp_i[DISP_W-1]}}, disp_i, 1'b0};
  assign seq_o    = pc_i + INSN_BYTES;
  assign target_o = pc_i + PIPE_AHEAD + offset;
endmodule

// File: rtl/cbu_pc_ctrl.sv
module cbu_pc_ctrl
  import cbu_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reset_vec_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic              flag_i,
  input  logic [ADDR_W-1:0] seq_i,
  input  logic [ADDR_W-1:0] target_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic              flush_o,
  output logic              illegal_o
);
  logic [ADDR_W-1:0] pc_q;
  logic [ADDR_W-1:0] slot_tgt_q;
  logic              slot_pend_q;
  logic              flush_q;
  logic              illegal_q;
  logic              cond_taken;

  assign cond_taken = ((op_i == OP_BT) && flag_i) || ((op_i == OP_BF) && !flag_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q        <= reset_vec_i;
      slot_tgt_q  <= '0;
      slot_pend_q <= 1'b0;
      flush_q     <= 1'b0;
      illegal_q   <= 1'b0;
    end else begin
      flush_q   <= 1'b0;
      illegal_q <= 1'b0;
      if (slot_pend_q) begin
        slot_pend_q <= 1'b0;
        pc_q        <= slot_tgt_q;
        illegal_q   <= op_is_branch(op_i);
      end else if (op_i == OP_BRA) begin
        slot_pend_q <= 1'b1;
        slot_tgt_q  <= target_i;
        pc_q        <= seq_i;
      end else if (cond_taken) begin
        pc_q    <= target_i;
        flush_q <= 1'b1;
      end else begin
        pc_q <= seq_i;
      end
    end
  end

  assign pc_o      = pc_q;
  assign flush_o   = flush_q;
  assign illegal_o = illegal_q;

  a_r7_slot_opens: assert property (@(posedge clk) disable iff (rst)
    ((op_i == OP_BRA) && !slot_pend_q) |=> (slot_pend_q && !flush_q));

  a_r8_illegal_in_slot: assert property (@(posedge clk) disable iff (rst)
    illegal_q |-> ($past(slot_pend_q) && !slot_pend_q));

  a_r5_flush_excl: assert property (@(posedge clk) disable iff (rst)
    flush_q |-> (!illegal_q && !slot_pend_q));

  a_r7_slot_closes: assert property (@(posedge clk) disable iff (rst)
    slot_pend_q |=> (!slot_pend_q && (pc_q == $past(slot_tgt_q))));
endmodule

// File: rtl/cond_branch_unit.sv
module cond_branch_unit
  import cbu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int DISP_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reset_vec_i,
  input  logic [OP_W-1:0]   op_class_i,
  input  logic [DATA_W-1:0] opnd_a_i,
  input  logic [DATA_W-1:0] opnd_b_i,
  input  logic [ADDR_W-1:0] op_pc_i,
  input  logic [DISP_W-1:0] disp_i,
  output logic              flag_o,
  output logic [ADDR_W-1:0] next_pc_o,
  output logic              flush_o,
  output logic              illegal_o
);
  logic              flag;
  logic [ADDR_W-1:0] seq_pc;
  logic [ADDR_W-1:0] tgt_pc;

  cbu_flag_unit #(.DATA_W(DATA_W)) u_flag (
    .clk    (clk),
    .rst    (rst),
    .op_i   (op_class_i),
    .a_i    (opnd_a_i),
    .b_i    (opnd_b_i),
    .flag_o (flag)
  );

  cbu_target_calc #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_tgt (
    .pc_i     (op_pc_i),
    .disp_i   (disp_i),
    .seq_o    (seq_pc),
    .target_o (tgt_pc)
  );

  cbu_pc_ctrl #(.ADDR_W(ADDR_W)) u_pc (
    .clk         (clk),
    .rst         (rst),
    .reset_vec_i (reset_vec_i),
    .op_i        (op_class_i),
    .flag_i      (flag),
    .seq_i       (seq_pc),
    .target_i    (tgt_pc),
    .pc_o        (next_pc_o),
    .flush_o     (flush_o),
    .illegal_o   (illegal_o)
  );

  assign flag_o = flag;

  a_r9_reset_pc: assert property (@(posedge clk)
    $past(rst) |-> (next_pc_o == $past(reset_vec_i) && !flag_o && !flush_o && !illegal_o));
endmodule

// File: tb/cond_branch_unit_tb.sv
module cond_branch_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] reset_vec = 32'h0000_1000;
  logic [3:0]  op = 4'd0;
  logic [31:0] a = '0, b = '0, pc = '0;
  logic [7:0]  disp = '0;
  logic        flag, flush, illegal;
  logic [31:0] npc;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cond_branch_unit u_dut (
    .clk(clk), .rst(rst), .reset_vec_i(reset_vec), .op_class_i(op),
    .opnd_a_i(a), .opnd_b_i(b), .op_pc_i(pc), .disp_i(disp),
    .flag_o(flag), .next_pc_o(npc), .flush_o(flush), .illegal_o(illegal)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y,
                       input logic [31:0] p, input logic [7:0] d);
    op = o; a = x; b = y; pc = p; disp = d;
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [31:0] tgt(input logic [31:0] p, input logic [7:0] d);
    return p + 32'd4 + {{23{d[7]}}, d, 1'b0};
  endfunction

  function automatic logic [31:0] sval(input int i);
    case (i)
      0: return 32'h0000_0000;
      1: return 32'h0000_0001;
      2: return 32'hFFFF_FFFF;
      3: return 32'h7FFF_FFFF;
      4: return 32'h8000_0000;
      5: return 32'h0000_0002;
      6: return 32'hFFFF_FFFE;
      default: return 32'h0000_00F0;
    endcase
  endfunction

  function automatic logic [7:0] dval(input int i);
    case (i)
      0: return 8'h00;
      1: return 8'h01;
      2: return 8'h7F;
      3: return 8'h80;
      4: return 8'hFF;
      default: return 8'h55;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] p;
    logic [31:0] t;
    logic [31:0] t2;
    logic        exp_f;

    repeat (3) @(negedge clk);
    // R9: values while reset is held and right after release
    check("R9 pc", npc, reset_vec);
    check("R9 flag", {31'd0, flag}, 32'd0);
    check("R9 flush", {31'd0, flush}, 32'd0);
    check("R9 illegal", {31'd0, illegal}, 32'd0);
    rst = 1'b0;
    check("R9 pc after release", npc, reset_vec);

    // R1, R2, R3 sweeps; R6 sequential next address
    p = 32'h0000_2000;
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        issue(4'd2, sval(i), sval(j), p, 8'h00);
        check("R1 signed ge", {31'd0, flag}, {31'd0, ($signed(sval(i)) >= $signed(sval(j)))});
        check("R6 sequential", npc, p + 32'd2);
        p = p + 32'd2;
        issue(4'd3, sval(i), sval(j), p, 8'h00);
        check("R2 unsigned ge", {31'd0, flag}, {31'd0, (sval(i) >= sval(j))});
        p = p + 32'd2;
        issue(4'd4, sval(i), sval(j), p, 8'h00);
        check("R3 test", {31'd0, flag}, {31'd0, ((sval(i) & sval(j)) == 32'd0)});
        p = p + 32'd2;
      end
    end

    // R4: non-writing classes keep the flag, for both values
    for (int f = 0; f < 2; f++) begin
      issue(4'd4, 32'd1, f ? 32'd0 : 32'd1, p, 8'h00);
      exp_f = (f != 0);
      for (int o = 0; o < 16; o++) begin
        if (o == 2 || o == 3 || o == 4 || o == 7) continue;
        if ((o == 5 && exp_f) || (o == 6 && !exp_f)) continue;
        issue(o[3:0], 32'hFFFF_0000, 32'h0000_FFFF, p, 8'h00);
        check("R4 flag held", {31'd0, flag}, {31'd0, exp_f});
        p = p + 32'd2;
      end
    end

    // R5, R6, R10, R11: conditional branches right after a flag write
    for (int f = 0; f < 2; f++) begin
      for (int k = 0; k < 6; k++) begin
        for (int br = 5; br <= 6; br++) begin
          p = 32'h0001_0000 + 32'(k * 64);
          issue(4'd4, 32'd3, f ? 32'd4 : 32'd1, p, 8'h00);
          p = p + 32'd2;
          issue(br[3:0], 32'd0, 32'd0, p, dval(k));
          if ((br == 5) == (f != 0)) begin
            check("R5 R10 R11 taken pc", npc, tgt(p, dval(k)));
            check("R5 flush", {31'd0, flush}, 32'd1);
            t = tgt(p, dval(k));
            issue(4'd0, 32'd0, 32'd0, t, 8'h00);
            check("R5 flush one cycle", {31'd0, flush}, 32'd0);
          end else begin
            check("R6 R10 not taken pc", npc, p + 32'd2);
            check("R6 no flush", {31'd0, flush}, 32'd0);
          end
        end
      end
    end

    // R7: delayed branch with a slot instruction that writes the flag
    for (int k = 0; k < 6; k++) begin
      p = 32'h0002_0000 + 32'(k * 256);
      t = tgt(p, dval(k));
      issue(4'd4, 32'd1, 32'd1, p - 32'd2, 8'h00);
      issue(4'd7, 32'd0, 32'd0, p, dval(k));
      check("R7 slot pc", npc, p + 32'd2);
      check("R7 no flush", {31'd0, flush}, 32'd0);
      issue(4'd4, 32'd0, 32'd0, p + 32'd2, 8'h00);
      check("R7 R11 target after slot", npc, t);
      check("R7 slot wrote flag", {31'd0, flag}, 32'd1);
      issue(4'd1, 32'd0, 32'd0, t, 8'h00);
      check("R7 resumes sequential", npc, t + 32'd2);
    end

    // R8: branches placed in a delay slot
    for (int br = 5; br <= 7; br++) begin
      p = 32'h0003_0000;
      t = tgt(p, 8'h10);
      t2 = tgt(p + 32'd2, 8'h20);
      issue(4'd4, 32'd0, 32'd0, p - 32'd2, 8'h00);
      if (br == 6) issue(4'd4, 32'd1, 32'd1, p - 32'd2, 8'h00);
      issue(4'd7, 32'd0, 32'd0, p, 8'h10);
      issue(br[3:0], 32'd0, 32'd0, p + 32'd2, 8'h20);
      check("R8 illegal raised", {31'd0, illegal}, 32'd1);
      check("R8 first target kept", npc, t);
      check("R8 second not taken", {31'd0, (npc == t2)}, 32'd0);
      check("R8 no flush", {31'd0, flush}, 32'd0);
      issue(4'd0, 32'd0, 32'd0, t, 8'h00);
      check("R8 illegal one cycle", {31'd0, illegal}, 32'd0);
      check("R8 sequential after", npc, t + 32'd2);
    end

    // R9: reset in mid-run restores the vector and clears state
    reset_vec = 32'h0000_0400;
    issue(4'd7, 32'd0, 32'd0, 32'h100, 8'h08);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    check("R9 mid-run pc", npc, 32'h0000_0400);
    issue(4'd0, 32'd0, 32'd0, 32'h400, 8'h00);
    check("R9 no stale slot", npc, 32'h402);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule